// File: doc/BRIEF.md
# Host Reset Output Sequencer

This block owns the active-low reset line that holds a host processor in reset while the power rails around it are brought up or taken down. Three power-mode conditions can pull the line low. A cold start from the unpowered state always does so. The start of a shutdown that ends in the reset mode always does so. The start of a shutdown that ends in the powerdown mode does so only when a configuration bit permits it.

Once the line is low, it stays low until a release timer runs out. The timer does not begin when the line is asserted. It begins on one of four sequencer events, selected by a 2-bit field. The timer length is a 4-bit code that maps to a fixed number of millisecond steps, and it counts an external 1 ms tick. A code of zero releases the line in the same cycle as the selected event.

The pad can be driven in push-pull or open-drain fashion. The drive is presented as an output enable plus a data bit.

Top module: `host_rst_seq`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `rst_n_o` is 0. It remains 0 until a selected trigger has been followed by its full release count.
- R2: A high `cold_boot_i` at a clock edge makes `rst_n_o` 0 from that edge on.
- R3: A high `shdn_reset_i` at a clock edge makes `rst_n_o` 0 from that edge on.
- R4: A high `shdn_pdown_i` makes `rst_n_o` 0 only when `pdown_assert_en_i` is 1. When that bit is 0, `shdn_pdown_i` has no effect.
- R5: `trig_sel_i` picks the event that starts the release timer: 0 = `ext_wakeup_i`, 1 = `seq1_done_i`, 2 = `seq2_done_i`, 3 = `rst_to_pdown_i`. Events on the other three inputs neither start the timer nor release the line.
- R6: `timer_code_i` value c gives a release count N: N = 0 for c = 0, N = 2^(c-1) for c = 1..10, and N = 1000 for c = 11..15. `rst_n_o` rises at the edge that samples the N-th `tick_i` after the trigger edge.
- R7: When the code is 0, `rst_n_o` rises at the same edge that samples the selected trigger.
- R8: An assertion cause (R2 to R4) that arrives while the timer runs cancels the timer. Ticks alone then never release the line; a new selected trigger is needed.
- R9: Trigger events and ticks that arrive while `rst_n_o` is 1 are ignored, and the line stays 1.
- R10: With `open_drain_i` = 0 the pad is push-pull: `pad_oe_o` = 1 and `pad_do_o` = `rst_n_o`. With `open_drain_i` = 1, `pad_do_o` = 0 and `pad_oe_o` = NOT `rst_n_o`.
- R11: The timer code is sampled when the trigger is accepted. Changing `timer_code_i` afterwards does not change the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cold_boot_i | input | 1 | Cold start from the unpowered state |
| shdn_reset_i | input | 1 | Start of a shutdown to the reset mode |
| shdn_pdown_i | input | 1 | Start of a shutdown to the powerdown mode |
| pdown_assert_en_i | input | 1 | Allows `shdn_pdown_i` to assert the line |
| trig_sel_i | input | 2 | Release trigger select |
| ext_wakeup_i | input | 1 | External wakeup event |
| seq1_done_i | input | 1 | End of the first power-up sub-sequence |
| seq2_done_i | input | 1 | End of the second power-up sub-sequence |
| rst_to_pdown_i | input | 1 | Transition from the reset mode to the powerdown mode |
| timer_code_i | input | 4 | Release timer code |
| tick_i | input | 1 | 1 ms tick, one cycle wide |
| open_drain_i | input | 1 | 1 = open-drain drive, 0 = push-pull drive |
| rst_n_o | output | 1 | Logical reset level, active low |
| pad_do_o | output | 1 | Pad data bit |
| pad_oe_o | output | 1 | Pad output enable |

## Verification
Each result appears one edge after the input that causes it. A cause sampled at an edge pulls `rst_n_o` low right after that edge. A trigger with code 0, or the N-th tick, raises it right after the sampling edge. The pad outputs follow `rst_n_o` with no added delay.

The bench changes inputs on the falling edge and reads outputs on the next falling edge. Every reading therefore sits exactly one rising edge after its stimulus. Release counts are measured by sending one tick at a time and reading the line after each one, so the bench gets the exact tick count at which the line rose.

// File: rtl/host_rst_pkg.sv
package host_rst_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned MS_W   = 10;
  localparam int unsigned MAX_MS = 1000;
  localparam int unsigned N_TRIG = 4;
  localparam int unsigned SEL_W  = $clog2(N_TRIG);

  typedef enum logic [SEL_W-1:0] {
    TRIG_EXT_WAKE = 2'd0,
    TRIG_SEQ1     = 2'd1,
    TRIG_SEQ2     = 2'd2,
    TRIG_R2PD     = 2'd3
  } trig_sel_e;

  // 0 -> 0, 1..10 -> powers of two, above -> MAX_MS
  function automatic logic [MS_W-1:0] code_to_ms(input logic [CODE_W-1:0] code);
    if (code == '0) return '0;
    else if (code <= 4'd10) return MS_W'(1) << (code - 1'b1);
    else return MS_W'(MAX_MS);
  endfunction
endpackage

// File: rtl/host_rst_trig_mux.sv
module host_rst_trig_mux #(
  parameter int unsigned N_TRIG = 4,
  localparam int unsigned SEL_W = $clog2(N_TRIG)
) (
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              fire_o
);
  logic [N_TRIG-1:0] hit;
  for (genvar g = 0; g < N_TRIG; g++) begin : g_sel
    assign hit[g] = trig_i[g] && (sel_i == SEL_W'(g));
  end
  assign fire_o = |hit;
endmodule

// File: rtl/host_rst_timer.sv
module host_rst_timer #(
  parameter int unsigned MS_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            start_i,
  input  logic [MS_W-1:0] limit_i,
  input  logic            tick_i,
  output logic            busy_o,
  output logic            expire_o
);
  logic            run_q;
  logic [MS_W-1:0] cnt_q, lim_q;
  logic            last_tick;

  assign last_tick = run_q && tick_i && ((cnt_q + 1'b1) == lim_q);
  assign expire_o  = !clear_i && ((start_i && limit_i == '0) || last_tick);
  assign busy_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clear_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && limit_i != '0) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (last_tick) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/host_rst_drive.sv
module host_rst_drive (
  input  logic open_drain_i,
  input  logic level_n_i,
  output logic do_o,
  output logic oe_o
);
  always_comb begin
    if (open_drain_i) begin
      do_o = 1'b0;
      oe_o = !level_n_i;
    end else begin
      do_o = level_n_i;
      oe_o = 1'b1;
    end
  end
endmodule

// File: rtl/host_rst_seq.sv
module host_rst_seq
  import host_rst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_boot_i,
  input  logic              shdn_reset_i,
  input  logic              shdn_pdown_i,
  input  logic              pdown_assert_en_i,
  input  logic [SEL_W-1:0]  trig_sel_i,
  input  logic              ext_wakeup_i,
  input  logic              seq1_done_i,
  input  logic              seq2_done_i,
  input  logic              rst_to_pdown_i,
  input  logic [CODE_W-1:0] timer_code_i,
  input  logic              tick_i,
  input  logic              open_drain_i,
  output logic              rst_n_o,
  output logic              pad_do_o,
  output logic              pad_oe_o
);
  logic asserted_q, cause, sel_fire, accept, busy, expire;
  logic [N_TRIG-1:0] trig_vec;

  assign cause    = cold_boot_i || shdn_reset_i || (shdn_pdown_i && pdown_assert_en_i);
  assign trig_vec = {rst_to_pdown_i, seq2_done_i, seq1_done_i, ext_wakeup_i};

  host_rst_trig_mux #(.N_TRIG(N_TRIG)) mux_i (
    .trig_i (trig_vec),
    .sel_i  (trig_sel_i),
    .fire_o (sel_fire)
  );

  // triggers count only while held and idle
  assign accept = sel_fire && asserted_q && !busy && !cause;

  host_rst_timer #(.MS_W(MS_W)) tmr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (cause),
    .start_i  (accept),
    .limit_i  (code_to_ms(timer_code_i)),
    .tick_i   (tick_i),
    .busy_o   (busy),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     asserted_q <= 1'b1;
    else if (cause)  asserted_q <= 1'b1;
    else if (expire) asserted_q <= 1'b0;
  end

  assign rst_n_o = !asserted_q;

  host_rst_drive drv_i (
    .open_drain_i (open_drain_i),
    .level_n_i    (rst_n_o),
    .do_o         (pad_do_o),
    .oe_o         (pad_oe_o)
  );
endmodule

// File: rtl/host_rst_seq_chk.sv
module host_rst_seq_chk
  import host_rst_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cold_boot_i,
  input logic              shdn_reset_i,
  input logic              shdn_pdown_i,
  input logic              pdown_assert_en_i,
  input logic [SEL_W-1:0]  trig_sel_i,
  input logic              ext_wakeup_i,
  input logic              seq1_done_i,
  input logic              seq2_done_i,
  input logic              rst_to_pdown_i,
  input logic [CODE_W-1:0] timer_code_i,
  input logic              tick_i,
  input logic              open_drain_i,
  input logic              rst_n_o,
  input logic              pad_do_o,
  input logic              pad_oe_o
);
  logic any_trig;
  assign any_trig = ext_wakeup_i || seq1_done_i || seq2_done_i || rst_to_pdown_i;

  assert_cold_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_boot_i |=> !rst_n_o);

  assert_shdn_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_reset_i |=> !rst_n_o);

  assert_pdown_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_n_o && !cold_boot_i && !shdn_reset_i && !pdown_assert_en_i) |=> rst_n_o);

  assert_pdown_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_pdown_i && pdown_assert_en_i) |=> !rst_n_o);

  assert_rise_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_n_o && !cold_boot_i && !shdn_reset_i && !shdn_pdown_i && !tick_i && !any_trig)
      |=> !rst_n_o);

  assert_released_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_n_o && !cold_boot_i && !shdn_reset_i && !shdn_pdown_i) |=> rst_n_o);

  assert_pad_od_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_drain_i |-> (!pad_do_o && pad_oe_o == !rst_n_o));

  assert_pad_pp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_drain_i |-> (pad_oe_o && pad_do_o == rst_n_o));
endmodule

bind host_rst_seq host_rst_seq_chk chk_i (.*);

// File: tb/host_rst_seq_tb_top.sv
module host_rst_seq_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cold_boot = 0, shdn_reset = 0, shdn_pdown = 0, pd_en = 0;
  logic [1:0] sel = 0;
  logic [3:0] trg = 0;
  logic [3:0] code = 0;
  logic tick = 0, od = 0;
  logic rst_n, pad_do, pad_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  host_rst_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cold_boot_i(cold_boot), .shdn_reset_i(shdn_reset),
    .shdn_pdown_i(shdn_pdown), .pdown_assert_en_i(pd_en), .trig_sel_i(sel),
    .ext_wakeup_i(trg[0]), .seq1_done_i(trg[1]), .seq2_done_i(trg[2]),
    .rst_to_pdown_i(trg[3]), .timer_code_i(code), .tick_i(tick),
    .open_drain_i(od), .rst_n_o(rst_n), .pad_do_o(pad_do), .pad_oe_o(pad_oe));

  function automatic int exp_ms(input int c);
    if (c == 0) return 0;
    if (c <= 10) return 1 << (c - 1);
    return 1000;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_cold();
    cold_boot = 1; step(); cold_boot = 0;
  endtask

  task automatic pulse_trig(input int s);
    trg = 4'(1 << s); step(); trg = 0;
  endtask

  task automatic pulse_tick();
    tick = 1; step(); tick = 0; step();
  endtask

  // ticks until release, capped
  task automatic measure(output int n);
    n = 0;
    while (!rst_n && n < 1100) begin
      pulse_tick(); n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset low", rst_n, 0);
    chk("R10 pp during reset oe", pad_oe, 1);
    rst_ni = 1; step();
    repeat (5) pulse_tick();
    chk("R1 held after reset", rst_n, 0);

    // R6/R7 code sweep, R5 select rotates
    for (int c = 0; c < 16; c++) begin
      sel = 2'(c); code = 4'(c);
      pulse_cold();
      chk("R2 cold low", rst_n, 0);
      pulse_trig(c % 4);
      if (c == 0) chk("R7 zero code immediate", rst_n, 1);
      measure(n);
      chk($sformatf("R6 ticks code %0d", c), n, exp_ms(c));
    end

    // R5 unselected triggers ignored
    sel = 2; code = 2;
    pulse_cold();
    pulse_trig(0); pulse_trig(1); pulse_trig(3);
    repeat (6) pulse_tick();
    chk("R5 unselected no release", rst_n, 0);
    pulse_trig(2); measure(n);
    chk("R5 selected releases", n, 2);

    // R9 triggers while released ignored
    repeat (4) begin pulse_trig(2); pulse_tick(); end
    chk("R9 released stays high", rst_n, 1);

    // R3
    shdn_reset = 1; step(); shdn_reset = 0;
    chk("R3 shutdown-reset low", rst_n, 0);

    // R8 cancel
    code = 3; pulse_trig(2); pulse_tick(); pulse_tick();
    shdn_reset = 1; step(); shdn_reset = 0;
    repeat (10) pulse_tick();
    chk("R8 cancelled timer no release", rst_n, 0);
    pulse_trig(2); measure(n);
    chk("R8 fresh count after retrigger", n, 4);

    // R4 gate
    pd_en = 0; shdn_pdown = 1; step(); shdn_pdown = 0;
    chk("R4 pdown disabled no effect", rst_n, 1);
    pd_en = 1; shdn_pdown = 1; step(); shdn_pdown = 0;
    chk("R4 pdown enabled asserts", rst_n, 0);

    // R10 open drain held and released
    od = 1; step();
    chk("R10 od held do", pad_do, 0);
    chk("R10 od held oe", pad_oe, 1);
    // R11 code latched
    code = 4; pulse_trig(2); code = 1;
    measure(n);
    chk("R11 latched code", n, 8);
    chk("R10 od released oe", pad_oe, 0);
    chk("R10 od released do", pad_do, 0);
    od = 0; step();
    chk("R10 pp released do", pad_do, 1);
    chk("R10 pp released oe", pad_oe, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule